// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Vector Generator

This block collects seven interrupt request sources raised by a serial-port register emulation layer: a transmit-empty event, a transmit-timeout event, a receive-data event, and host writes to the modem-control, line-control, divisor and FIFO-control registers. Each request is latched as pending. The pending set is filtered by one enable bit per source and by a global master bit. The result drives a single registered interrupt line towards a host CPU.

The block also assembles an 8-bit vector byte for the host's interrupt response. The top four bits come from a programmable register. Bit 0 is always zero. Bits 3..1 depend on the `vec_mode` input. When `vec_mode` is 1, they carry a fixed 3-bit code for the highest-priority visible source. When `vec_mode` is 0, they hold whatever software last wrote, so the whole byte can serve as an opcode.

The host clears events through `ack`. Each assertion of `ack` retires only the current winner, and the vector then moves on to the next visible source. The cleared source is reported on a one-hot clear output so that the request logic can drop its condition.

Top module: `irq_vector_gen`

## Requirements
- R1: After a synchronous reset, the enable register, the vector register and all pending flags are 0. As a result, `irq_out` is 0, `vec_byte` is 0x00, and `reg_rdata` is 0x00 for both register selects.
- R2: Enable register bit 7 is the master bit. While it is 0, `irq_out` stays 0 and the status code is 000, whatever bits 6..0 and the pending set hold.
- R3: Enable register bit i (0..6) unmasks request input `req_in[i]`. The mapping is: 6 transmit empty, 5 transmit timeout, 4 receive data, 3 modem-control write, 2 line-control write, 1 divisor write (low and high byte share this one source), 0 FIFO-control write.
- R4: Among the visible sources (pending AND enabled AND master set), the highest index wins. The winner's status code is its index plus one.
- R5: With `vec_mode`=1, `vec_byte[3:1]` equals the winner's code. The codes are 111 transmit empty, 110 timeout, 101 receive, 100 modem, 011 line, 010 divisor, 001 FIFO control, and 000 when no source is visible.
- R6: With `vec_mode`=0, `vec_byte[3:1]` and the read-back of the vector register carry bits 3..1 of the last write to the vector register.
- R7: `vec_byte[7:4]` always equals bits 7..4 of the last vector-register write, and `vec_byte[0]` is always 0.
- R8: A high `req_in[i]` at a clock edge makes source i pending. When `ack` is high, `clr_out` is, in the same cycle, the one-hot flag of the current winner. That source is no longer pending after the edge, and the vector shows the next winner.
- R9: `irq_out` is a register output. In every cycle after reset it equals the OR of the visible sources held at that moment.
- R10: A pending source whose enable bit (or the master bit) is cleared stays pending but is hidden. It becomes visible again when it is re-enabled.
- R11: `ack` with no visible source clears nothing and leaves `clr_out` at 0. A request and a clear of the same source in the same cycle leave that source pending.
- R12: `reg_rdata` returns the enable register when `reg_sel`=0, and the current `vec_byte` when `reg_sel`=1. Writes use `reg_wr` with `reg_sel` selecting the target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the vector register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| req_in | input | 7 | Request set pulses, index = priority |
| ack | input | 1 | Host acknowledge of the current winner |
| clr_out | output | 7 | One-hot flag of the source cleared by `ack` |
| vec_mode | input | 1 | 1: status code in bits 3..1; 0: written bits |
| irq_out | output | 1 | Registered interrupt request |
| vec_byte | output | 8 | Vector byte for the host |

## Verification
The assertions rely on `req_in`, `ack`, `reg_wr` and `vec_mode` being synchronous and settled at each rising edge. `ack` may arrive at any time, including when nothing is visible. The stimulus drives every input only at falling edges. It mixes sparse random request pulses, acknowledges and register writes, and toggles `vec_mode` freely. This reaches masked-pending, request-during-clear and idle-acknowledge situations without ever changing an input near the sampling edge.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
    localparam int NUM_SRC = 7;
    localparam int CODE_W  = $clog2(NUM_SRC + 1);
    localparam int DATA_W  = 8;
    localparam int HI_W    = DATA_W - CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE      = 3'd0,
        SRC_FIFO_CTL  = 3'd1,
        SRC_DIV_LATCH = 3'd2,
        SRC_LINE_CTL  = 3'd3,
        SRC_MODEM_CTL = 3'd4,
        SRC_RX_DATA   = 3'd5,
        SRC_TX_TOUT   = 3'd6,
        SRC_TX_EMPTY  = 3'd7
    } src_code_e;

    typedef struct packed {
        logic               master;
        logic [NUM_SRC-1:0] src_en;
    } enable_reg_t;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [CODE_W-1:0] mid;
    } vector_reg_t;

    // Highest set index wins; code = index + 1, zero when nothing set.
    function automatic src_code_e code_of(input logic [NUM_SRC-1:0] v);
        src_code_e c;
        c = SRC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (v[i]) c = src_code_e'(CODE_W'(i + 1));
        end
        return c;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irqvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output enable_reg_t       en_q,
    output enable_reg_t       en_nxt,
    output vector_reg_t       vec_q
);
    vector_reg_t vec_nxt;

    always_comb begin
        en_nxt  = en_q;
        vec_nxt = vec_q;
        if (wr_en && !wr_sel) en_nxt = enable_reg_t'(wdata);
        if (wr_en && wr_sel)  vec_nxt = vector_reg_t'(wdata[DATA_W-1:1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            vec_q <= '0;
        end else begin
            en_q  <= en_nxt;
            vec_q <= vec_nxt;
        end
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import irqvec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] pend_nxt
);
    // A new request overrides a clear of the same source.
    always_comb pend_nxt = (pend_q & ~clr) | req;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_nxt;
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr)); // R8
    AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> ((pend_q & $past(req)) == $past(req))); // R8
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~req)) |=> ((pend_q & $past(clr & ~req)) == '0)); // R8
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R10
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irqvec_pkg::*;
(
    input  logic [NUM_SRC-1:0] vis,
    output logic [NUM_SRC-1:0] grant,
    output src_code_e          code
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
        if (i == NUM_SRC - 1) begin : g_top
            assign grant[i] = vis[i];
        end else begin : g_low
            assign grant[i] = vis[i] & ~(|vis[NUM_SRC-1:i+1]);
        end
    end

    assign code = code_of(vis);
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irqvec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [6:0]  req_in,
    input  logic        ack,
    output logic [6:0]  clr_out,
    input  logic        vec_mode,
    output logic        irq_out,
    output logic [7:0]  vec_byte
);
    enable_reg_t        en_q, en_nxt;
    vector_reg_t        vec_q;
    logic [NUM_SRC-1:0] pend_q, pend_nxt, vis, vis_nxt, grant, clr;
    src_code_e          code;
    logic [CODE_W-1:0]  mid_sel;
    logic               irq_q;

    irq_cfg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_sel(reg_sel),
        .wdata(reg_wdata), .en_q(en_q), .en_nxt(en_nxt), .vec_q(vec_q)
    );

    irq_pending u_pend (
        .clk(clk), .rst(rst), .req(req_in), .clr(clr),
        .pend_q(pend_q), .pend_nxt(pend_nxt)
    );

    always_comb vis = en_q.master ? (pend_q & en_q.src_en) : '0;

    irq_prio_pick u_pick (.vis(vis), .grant(grant), .code(code));

    always_comb clr = ack ? grant : '0;
    assign clr_out = clr;

    // Registered from next-state so it lines up with the pending flags.
    always_comb vis_nxt = en_nxt.master ? (pend_nxt & en_nxt.src_en) : '0;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |vis_nxt;
    end
    assign irq_out = irq_q;

    always_comb mid_sel = vec_mode ? code : vec_q.mid;
    assign vec_byte  = {vec_q.hi, mid_sel, 1'b0};
    assign reg_rdata = reg_sel ? vec_byte : en_q;

    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (rst)
        !en_q.master |-> !irq_out); // R2
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        (vec_mode && !irq_out) |-> (vec_byte[3:1] == 3'd0)); // R5
    AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        (vec_mode && irq_out) |-> (vec_byte[3:1] != 3'd0)); // R9
    AST_GRANT_CODE: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) == (code == SRC_NONE)); // R4
endmodule

// File: tb/irq_vector_gen_tb_top.sv
module irq_vector_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_sel = 1'b0, ack = 1'b0, vec_mode = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [6:0] req_in = '0;
    logic [7:0] reg_rdata, vec_byte;
    logic [6:0] clr_out;
    logic       irq_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [6:0] m_pend = '0;
    logic [7:0] m_en = '0;
    logic [3:0] m_hi = '0;
    logic [2:0] m_mid = '0;

    always #2 clk = ~clk;

    irq_vector_gen dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
        .ack(ack), .clr_out(clr_out), .vec_mode(vec_mode),
        .irq_out(irq_out), .vec_byte(vec_byte)
    );

    function automatic logic [6:0] f_vis();
        return m_en[7] ? (m_pend & m_en[6:0]) : 7'd0;
    endfunction

    function automatic logic [2:0] f_code();
        logic [2:0] c = 3'd0;
        logic [6:0] v = f_vis();
        for (int i = 0; i < 7; i++) if (v[i]) c = 3'(i + 1);
        return c;
    endfunction

    function automatic logic [6:0] f_grant();
        logic [2:0] c = f_code();
        return (c == 3'd0) ? 7'd0 : (7'd1 << (c - 3'd1));
    endfunction

    function automatic logic [7:0] f_vec(input logic mode);
        return {m_hi, (mode ? f_code() : m_mid), 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] rq, input logic a, input logic wr,
                        input logic sel, input logic [7:0] wd, input logic md);
        logic [6:0] exp_clr;
        @(negedge clk);
        req_in = rq; ack = a; reg_wr = wr; reg_sel = sel; reg_wdata = wd; vec_mode = md;
        #1;
        exp_clr = a ? f_grant() : 7'd0;
        chk((exp_clr == 0 && a) ? "R11" : "R8", {1'b0, clr_out}, {1'b0, exp_clr});
        m_pend = (m_pend & ~exp_clr) | rq;
        if (wr) begin
            if (sel) begin m_hi = wd[7:4]; m_mid = wd[3:1]; end
            else m_en = wd;
        end
        @(posedge clk); #1;
        chk("R9", {7'd0, irq_out}, {7'd0, |f_vis()});
        chk(md ? "R5" : "R6", vec_byte, f_vec(md));
        chk("R12", reg_rdata, sel ? f_vec(md) : m_en);
        req_in = '0; ack = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", {7'd0, irq_out}, 8'd0);
        chk("R1", vec_byte, 8'd0);
        chk("R1", reg_rdata, 8'd0);
        reg_sel = 1'b1; vec_mode = 1'b1; #1;
        chk("R1", reg_rdata, 8'd0);

        // R2: master off hides everything
        step(7'h00, 0, 1, 0, 8'h7F, 1);
        step(7'h7F, 0, 0, 0, 8'h00, 1);
        chk("R2", {7'd0, irq_out}, 8'd0);
        chk("R2", {5'd0, vec_byte[3:1]}, 8'd0);
        step(7'h00, 0, 1, 0, 8'hFF, 1);
        chk("R2", {7'd0, irq_out}, 8'd1);

        // R4: acks walk down the priority order
        for (int k = 7; k >= 1; k--) begin
            chk("R4", {5'd0, vec_byte[3:1]}, 8'(k));
            step(7'h00, 1, 0, 1, 8'h00, 1);
        end
        chk("R4", {5'd0, vec_byte[3:1]}, 8'd0);
        chk("R4", {7'd0, irq_out}, 8'd0);

        // R3: single enable for modem-control source
        step(7'h00, 0, 1, 0, 8'h88, 1);
        step(7'h48, 0, 0, 1, 8'h00, 1);
        chk("R3", {5'd0, vec_byte[3:1]}, 8'd4);

        // R10: masked transmit-empty re-appears when enabled
        step(7'h00, 0, 1, 0, 8'hC8, 1);
        chk("R10", {5'd0, vec_byte[3:1]}, 8'd7);
        step(7'h00, 1, 0, 1, 8'h00, 1);
        chk("R10", {5'd0, vec_byte[3:1]}, 8'd4);

        // R11: request wins over clear; idle ack clears nothing
        step(7'h08, 1, 0, 1, 8'h00, 1);
        chk("R11", {5'd0, vec_byte[3:1]}, 8'd4);
        step(7'h00, 1, 0, 1, 8'h00, 1);
        step(7'h00, 1, 0, 0, 8'h00, 1);
        step(7'h00, 1, 0, 0, 8'h00, 1);
        chk("R11", {7'd0, irq_out}, 8'd0);

        // R6/R7: opcode mode read-back
        step(7'h00, 0, 1, 1, 8'hA5, 0);
        chk("R7", vec_byte, 8'hA4);
        chk("R6", {5'd0, vec_byte[3:1]}, 8'd2);
        step(7'h10, 0, 1, 0, 8'hFF, 0);
        chk("R6", vec_byte, 8'hA4);
        step(7'h00, 0, 0, 1, 8'h00, 1);
        chk("R7", vec_byte, 8'hAA);

        for (int n = 0; n < 3000; n++) begin
            logic [6:0] rq;
            logic       a, wr, sel, md;
            logic [7:0] wd;
            rq  = ($urandom % 4 == 0) ? 7'($urandom) & 7'($urandom) : 7'd0;
            a   = ($urandom % 4 == 0);
            wr  = ($urandom % 16 == 0);
            sel = $urandom % 2;
            md  = ($urandom % 4 != 0);
            wd  = 8'($urandom);
            if (wr && !sel && ($urandom % 2 == 0)) wd[7] = 1'b1;
            step(rq, a, wr, sel, wd, md);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule